// File: doc/BRIEF.md
# Stored-Constant GHASH Tag Engine

The engine builds a GCM-style authentication tag over one frame, with every signal of the frame padded to a single 128-bit block. All block-cipher results are precomputed and written into a small constant store before use: the hash subkey H, the encrypted pre-counter block E(K,Y0), and one encrypted counter block per possible plaintext block. Encrypting a plaintext block is then a single XOR with a stored counter. Authentication folds the additional data block, the ciphertext blocks and a final length block into a GF(2^128) accumulator. The tag is the accumulator XOR E(K,Y0).

Software drives a command port carrying an opcode, an AAD block, a data block and a counter index. The commands are: open a frame with its AAD, add one plaintext block, close the frame, hash a single block together with its AAD in one step, and hash a single block with no AAD. Each fold takes one multiply. The multiply works through one bit of the operand per cycle. Commands presented while the engine is busy are dropped.

Top module: `ghash_tag_engine`

## Requirements
- R1: An accepted add-block (opcode 2) or single-shot command outputs ciphertext = data block XOR stored counter block [index] on `ct_out`, with `ct_valid` high for exactly the one cycle after acceptance. `ct_valid` and `tag_valid` are never high together.
- R2: Every fold computes X <- (X XOR B) * H in GF(2^128), using GCM bit order (bit 127 of the vector is the x^0 coefficient) and the polynomial x^128+x^7+x^2+x+1. Open-frame (opcode 1) clears X and then folds the AAD block.
- R3: Close-frame (opcode 3) folds the length block {len(A), len(C)}, two 64-bit bit counts. len(A) is 0x80 when the frame was opened with AAD, and len(C) is 128 times the number of accepted blocks. The tag is then X XOR E(K,Y0).
- R4: Single-shot (opcode 4) clears X, then folds the AAD, the ciphertext of one block and the length block {0x80, 0x80}, in that order, and produces a tag.
- R5: Single-shot without AAD (opcode 5) clears X and folds only the ciphertext and the length block {0, 0x80}. With an all-zero key's constants and a zero plaintext, it yields the standard GCM tag ab6e47d42cec13bdf53a67b21257bddf.
- R6: `tag_out` carries the most significant TAG_BITS bits of the 128-bit tag.
- R7: An add-block command arriving after NUM_CTR accepted blocks sets `err_full`. That command produces no ciphertext and leaves the accumulator unchanged. Open-frame and the single-shot commands clear `err_full`.
- R8: `cmd_ready` is low while work is pending, and a command presented while `cmd_ready` is low has no effect.
- R9: After reset `busy`, `ct_valid`, `tag_valid` and `err_full` are low and `tag_out` is zero.
- R10: `tag_valid` is a single-cycle pulse. `tag_out` holds its value until the next tag is produced.
- R11: Constant-store writes select H (select 0), E(K,Y0) (select 1) or counter block `ks_idx` (select 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ks_we | input | 1 | Constant-store write strobe |
| ks_sel | input | 2 | Constant select: 0 H, 1 E(K,Y0), 2 counter block |
| ks_idx | input | IDX_W | Counter-block slot for select 2 |
| ks_wdata | input | 128 | Constant value |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_op | input | 3 | 0 none, 1 open, 2 add block, 3 close, 4 single-shot, 5 single-shot without AAD |
| cmd_idx | input | IDX_W | Counter-block index for the data block |
| cmd_aad | input | 128 | AAD block |
| cmd_blk | input | 128 | Plaintext block |
| ct_valid | output | 1 | Ciphertext strobe |
| ct_out | output | 128 | Ciphertext block |
| tag_valid | output | 1 | Tag strobe |
| tag_out | output | TAG_BITS | Tag, most significant bits |
| busy | output | 1 | Fold or finalisation in progress |
| err_full | output | 1 | Block limit exceeded |

## Verification
The bench instantiates the engine twice with NUM_CTR = 4. One instance has TAG_BITS = 128 and the other TAG_BITS = 32. The small counter depth brings the block-limit error within reach after four additions. The narrow instance exposes the truncation against the same expected tags. The single-block case without AAD is compared against a published GCM vector. The multi-block frames, the single-shot command with AAD and the overflow frame are compared against a carry-less multiply-and-reduce model written in the bench.

// File: rtl/ghash_pkg.sv
package ghash_pkg;
    localparam int BLK_W = 128;
    typedef logic [BLK_W-1:0] blk_t;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_OPEN    = 3'd1,
        OP_ADD     = 3'd2,
        OP_CLOSE   = 3'd3,
        OP_ONCE    = 3'd4,
        OP_ONCE_NA = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        KS_H   = 2'd0,
        KS_EY0 = 2'd1,
        KS_CTR = 2'd2
    } ks_sel_e;

    typedef struct packed {
        logic aad;
        logic ct;
        logic len;
    } pend_t;

    localparam blk_t GF_RED = {8'hE1, 120'h0};
    localparam logic [63:0] AAD_BITS = 64'h80;

    // multiply by x in GCM's reflected bit order
    function automatic blk_t gf_times_x(blk_t v);
        return v[0] ? ((v >> 1) ^ GF_RED) : (v >> 1);
    endfunction

    function automatic blk_t make_len_block(logic with_aad, logic [63:0] nblk);
        logic [63:0] cbits;
        cbits = nblk << 7;
        return {(with_aad ? AAD_BITS : 64'h0), cbits};
    endfunction
endpackage

// File: rtl/ghash_keystore.sv
module ghash_keystore
    import ghash_pkg::*;
#(
    parameter int NUM_CTR = 64,
    parameter int IDX_W   = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [IDX_W-1:0] widx,
    input  blk_t             wdata,
    input  logic [IDX_W-1:0] ridx,
    output blk_t             hkey,
    output blk_t             ey0,
    output blk_t             ectr
);
    blk_t ctr_mem [NUM_CTR];

    always_ff @(posedge clk) begin
        if (rst) begin
            hkey <= '0;
            ey0  <= '0;
        end else if (we) begin
            if (ks_sel_e'(sel) == KS_H)   hkey <= wdata;
            if (ks_sel_e'(sel) == KS_EY0) ey0  <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (we && ks_sel_e'(sel) == KS_CTR && int'(widx) < NUM_CTR)
            ctr_mem[widx] <= wdata;
    end

    assign ectr = ctr_mem[ridx];

    p_sel_legal_r11: assert property (@(posedge clk) disable iff (rst)
        we |-> sel != 2'd3);
endmodule

// File: rtl/ghash_serial_mul.sv
module ghash_serial_mul
    import ghash_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  blk_t opa,
    input  blk_t hkey,
    output logic run,
    output logic done,
    output blk_t prod
);
    localparam int CNT_W = $clog2(BLK_W);

    blk_t             yreg, vreg, zreg;
    logic [CNT_W-1:0] bitn;
    blk_t             z_next;

    always_comb begin
        z_next = yreg[BLK_W-1] ? (zreg ^ vreg) : zreg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            done <= 1'b0;
            yreg <= '0;
            vreg <= '0;
            zreg <= '0;
            bitn <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                run  <= 1'b1;
                yreg <= opa;
                vreg <= hkey;
                zreg <= '0;
                bitn <= '0;
            end else if (run) begin
                zreg <= z_next;
                vreg <= gf_times_x(vreg);
                yreg <= yreg << 1;
                bitn <= bitn + 1'b1;
                if (bitn == CNT_W'(BLK_W - 1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign prod = zreg;

    p_start_idle_r2: assert property (@(posedge clk) disable iff (rst)
        start |-> !run && !done);
    p_done_once_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !run);
endmodule

// File: rtl/ghash_tag_engine.sv
module ghash_tag_engine
    import ghash_pkg::*;
#(
    parameter int NUM_CTR  = 64,
    parameter int TAG_BITS = 128,
    localparam int IDX_W   = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ks_we,
    input  logic [1:0]          ks_sel,
    input  logic [IDX_W-1:0]    ks_idx,
    input  logic [127:0]        ks_wdata,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [2:0]          cmd_op,
    input  logic [IDX_W-1:0]    cmd_idx,
    input  logic [127:0]        cmd_aad,
    input  logic [127:0]        cmd_blk,
    output logic                ct_valid,
    output logic [127:0]        ct_out,
    output logic                tag_valid,
    output logic [TAG_BITS-1:0] tag_out,
    output logic                busy,
    output logic                err_full
);
    localparam int CNT_W = $clog2(NUM_CTR + 1);

    blk_t hkey, ey0, ectr, ct_calc;
    blk_t x_acc, aad_q, ct_q, tag_q;
    blk_t fold_blk, mul_prod;
    pend_t pend;
    logic fin, has_aad, accept, issue, do_final;
    logic mul_run, mul_done;
    logic [CNT_W-1:0] blk_cnt;

    ghash_keystore #(.NUM_CTR(NUM_CTR), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst), .we(ks_we), .sel(ks_sel), .widx(ks_idx),
        .wdata(ks_wdata), .ridx(cmd_idx), .hkey(hkey), .ey0(ey0), .ectr(ectr)
    );

    assign ct_calc  = cmd_blk ^ ectr;
    assign busy     = (pend != '0) || fin || mul_run || mul_done;
    assign cmd_ready = !busy;
    assign accept   = cmd_valid && !busy;
    assign issue    = (pend != '0) && !mul_run && !mul_done;
    assign do_final = fin && (pend == '0) && !mul_run && !mul_done;

    // fold order: AAD, then ciphertext, then length block
    always_comb begin
        if (pend.aad)     fold_blk = aad_q;
        else if (pend.ct) fold_blk = ct_q;
        else              fold_blk = make_len_block(has_aad, 64'(blk_cnt));
    end

    ghash_serial_mul u_mul (
        .clk(clk), .rst(rst), .start(issue), .opa(x_acc ^ fold_blk),
        .hkey(hkey), .run(mul_run), .done(mul_done), .prod(mul_prod)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_acc     <= '0;
            aad_q     <= '0;
            ct_q      <= '0;
            tag_q     <= '0;
            pend      <= '0;
            fin       <= 1'b0;
            has_aad   <= 1'b0;
            blk_cnt   <= '0;
            err_full  <= 1'b0;
            ct_valid  <= 1'b0;
            ct_out    <= '0;
            tag_valid <= 1'b0;
        end else begin
            ct_valid  <= 1'b0;
            tag_valid <= 1'b0;
            if (mul_done) x_acc <= mul_prod;
            if (issue) begin
                if (pend.aad)     pend.aad <= 1'b0;
                else if (pend.ct) pend.ct  <= 1'b0;
                else              pend.len <= 1'b0;
            end
            if (do_final) begin
                tag_q     <= x_acc ^ ey0;
                tag_valid <= 1'b1;
                fin       <= 1'b0;
            end
            if (accept) begin
                unique case (op_e'(cmd_op))
                    OP_OPEN: begin
                        x_acc    <= '0;
                        blk_cnt  <= '0;
                        has_aad  <= 1'b1;
                        err_full <= 1'b0;
                        aad_q    <= cmd_aad;
                        pend     <= '{aad: 1'b1, ct: 1'b0, len: 1'b0};
                    end
                    OP_ADD: begin
                        if (blk_cnt == CNT_W'(NUM_CTR)) begin
                            err_full <= 1'b1;
                        end else begin
                            ct_q     <= ct_calc;
                            ct_out   <= ct_calc;
                            ct_valid <= 1'b1;
                            blk_cnt  <= blk_cnt + 1'b1;
                            pend     <= '{aad: 1'b0, ct: 1'b1, len: 1'b0};
                        end
                    end
                    OP_CLOSE: begin
                        pend <= '{aad: 1'b0, ct: 1'b0, len: 1'b1};
                        fin  <= 1'b1;
                    end
                    OP_ONCE, OP_ONCE_NA: begin
                        x_acc    <= '0;
                        aad_q    <= cmd_aad;
                        ct_q     <= ct_calc;
                        ct_out   <= ct_calc;
                        ct_valid <= 1'b1;
                        blk_cnt  <= CNT_W'(1);
                        err_full <= 1'b0;
                        has_aad  <= (op_e'(cmd_op) == OP_ONCE);
                        pend     <= '{aad: (op_e'(cmd_op) == OP_ONCE), ct: 1'b1, len: 1'b1};
                        fin      <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign tag_out = tag_q[BLK_W-1 -: TAG_BITS];

    p_no_overlap_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ct_valid, tag_valid}));
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy) |=> !ct_valid);
    p_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && op_e'(cmd_op) == OP_ADD && blk_cnt == CNT_W'(NUM_CTR)) |=> err_full && !ct_valid);
    p_tag_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        tag_valid |=> !tag_valid);
    p_tag_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !tag_valid |-> $stable(tag_out));
endmodule

// File: tb/test_ghash_tag_engine.sv
module test_ghash_tag_engine;
    typedef logic [127:0] b128;

    localparam int NCTR = 4;
    localparam int IW   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic ks_we = 1'b0;
    logic [1:0] ks_sel = '0;
    logic [IW-1:0] ks_idx = '0;
    b128 ks_wdata = '0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [IW-1:0] cmd_idx = '0;
    b128 cmd_aad = '0, cmd_blk = '0;

    logic cmd_ready, ct_valid, tag_valid, busy, err_full;
    b128 ct_out, tag_out;
    logic cmd_ready2, ct_valid2, tag_valid2, busy2, err_full2;
    b128 ct_out2;
    logic [31:0] tag_out2;

    ghash_tag_engine #(.NUM_CTR(NCTR), .TAG_BITS(128)) i_ghash_tag_engine (
        .clk(clk), .rst(rst), .ks_we(ks_we), .ks_sel(ks_sel), .ks_idx(ks_idx),
        .ks_wdata(ks_wdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_aad(cmd_aad), .cmd_blk(cmd_blk),
        .ct_valid(ct_valid), .ct_out(ct_out), .tag_valid(tag_valid),
        .tag_out(tag_out), .busy(busy), .err_full(err_full));

    ghash_tag_engine #(.NUM_CTR(NCTR), .TAG_BITS(32)) i_ghash_tag_engine_t32 (
        .clk(clk), .rst(rst), .ks_we(ks_we), .ks_sel(ks_sel), .ks_idx(ks_idx),
        .ks_wdata(ks_wdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready2),
        .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_aad(cmd_aad), .cmd_blk(cmd_blk),
        .ct_valid(ct_valid2), .ct_out(ct_out2), .tag_valid(tag_valid2),
        .tag_out(tag_out2), .busy(busy2), .err_full(err_full2));

    int nchk = 0, nfail = 0;
    bit finished = 1'b0;

    b128 exp_ct[$];
    b128 exp_tag[$];
    b128 exp_tag32[$];
    b128 last_tag = '0;

    localparam b128 HK  = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
    localparam b128 EY  = 128'h58e2fccefa7e3061367f1d57a4e7455a;
    b128 ctr [NCTR];

    // reference model state
    b128 mx;
    int  mcnt;
    bit  maad;

    task automatic check(input bit ok, input string req, input b128 act, input b128 expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // carry-less product with polynomial reduction, coefficients reflected
    function automatic b128 gmul(b128 a, b128 b);
        logic [255:0] p;
        b128 r;
        p = '0;
        for (int i = 0; i < 128; i++)
            for (int j = 0; j < 128; j++)
                if (a[127-i] && b[127-j]) p[i+j] = ~p[i+j];
        for (int k = 254; k >= 128; k--) begin
            if (p[k]) begin
                p[k] = 1'b0;
                p[k-128] = ~p[k-128];
                p[k-127] = ~p[k-127];
                p[k-126] = ~p[k-126];
                p[k-121] = ~p[k-121];
            end
        end
        for (int j = 0; j < 128; j++) r[127-j] = p[j];
        return r;
    endfunction

    function automatic b128 lenblk(bit a, int n);
        logic [63:0] cb;
        cb = 64'(n) * 64'd128;
        return {(a ? 64'h80 : 64'h0), cb};
    endfunction

    task automatic push_tag(input b128 t);
        exp_tag.push_back(t);
        exp_tag32.push_back(t);
    endtask

    task automatic drive(input logic [2:0] op, input b128 aad, input b128 blk, input int idx);
        cmd_op = op; cmd_aad = aad; cmd_blk = blk; cmd_idx = IW'(idx);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op = 3'd0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // issue a command when idle and update the model
    task automatic cmd(input logic [2:0] op, input b128 aad, input b128 blk, input int idx);
        b128 c;
        wait_idle();
        c = blk ^ ctr[idx];
        case (op)
            3'd1: begin mx = gmul(aad, HK); mcnt = 0; maad = 1'b1; end
            3'd2: if (mcnt < NCTR) begin
                      exp_ct.push_back(c);
                      mx = gmul(mx ^ c, HK); mcnt++;
                  end
            3'd3: begin
                      mx = gmul(mx ^ lenblk(maad, mcnt), HK);
                      push_tag(mx ^ EY);
                  end
            3'd4: begin
                      exp_ct.push_back(c);
                      mx = gmul(aad, HK); mx = gmul(mx ^ c, HK);
                      mcnt = 1; maad = 1'b1;
                      mx = gmul(mx ^ lenblk(1'b1, 1), HK);
                      push_tag(mx ^ EY);
                  end
            3'd5: begin
                      exp_ct.push_back(c);
                      mx = gmul(c, HK);
                      mcnt = 1; maad = 1'b0;
                      mx = gmul(mx ^ lenblk(1'b0, 1), HK);
                      push_tag(mx ^ EY);
                  end
            default: ;
        endcase
        drive(op, aad, blk, idx);
    endtask

    // per-clock comparison against the model's expectation queues
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (ct_valid) begin
                if (exp_ct.size() == 0) check(1'b0, "R1 unexpected ciphertext", ct_out, '0);
                else begin
                    b128 e;
                    e = exp_ct.pop_front();
                    check(ct_out == e, "R1 ciphertext", ct_out, e);
                end
            end
            if (tag_valid) begin
                if (exp_tag.size() == 0) check(1'b0, "R3 unexpected tag", tag_out, '0);
                else begin
                    b128 e;
                    e = exp_tag.pop_front();
                    check(tag_out == e, "R3 tag", tag_out, e);
                    last_tag = e;
                end
            end
            if (tag_valid2) begin
                if (exp_tag32.size() == 0) check(1'b0, "R6 unexpected tag", 128'(tag_out2), '0);
                else begin
                    b128 e;
                    e = exp_tag32.pop_front();
                    check(tag_out2 == e[127:96], "R6 truncated tag", 128'(tag_out2), 128'(e[127:96]));
                end
            end
        end
    end

    task automatic summary();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=%h expected=%h", 1, 0);
            summary();
        end
    end

    initial begin
        b128 a1, a2, p1, p2, p3;
        ctr[0] = 128'h0388dace60b6a392f328c2b971b2fe78;
        ctr[1] = 128'h5a17c3e4_99b0_21fe_0d3c_7788aa5511ee;
        ctr[2] = 128'hf00dcafe_1234_5678_9abc_def012345678;
        ctr[3] = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
        a1 = 128'hfeedfacedeadbeeffeedfacedeadbeef;
        a2 = 128'habaddad2abaddad2abaddad2abaddad2;
        p1 = 128'hd9313225f88406e5a55909c5aff5269a;
        p2 = 128'h86a7a9531534f7da2e4c303d8a318a72;
        p3 = 128'h1c3c0c95956809532fcf0e2449a6b525;
        mx = '0; mcnt = 0; maad = 1'b0;

        repeat (3) @(negedge clk);
        // R9: reset state
        check(!busy && !ct_valid && !tag_valid && !err_full && tag_out == '0 && cmd_ready,
              "R9 reset state", {busy, ct_valid, tag_valid, err_full}, '0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !err_full && tag_out == '0, "R9 after release", tag_out, '0);

        // R11: load constants
        ks_we = 1'b1;
        ks_sel = 2'd0; ks_wdata = HK; @(negedge clk);
        ks_sel = 2'd1; ks_wdata = EY; @(negedge clk);
        ks_sel = 2'd2;
        for (int i = 0; i < NCTR; i++) begin
            ks_idx = IW'(i); ks_wdata = ctr[i]; @(negedge clk);
        end
        ks_we = 1'b0;

        // R5: published vector, model sanity too
        cmd(3'd5, '0, '0, 0);
        check(exp_tag[exp_tag.size()-1] == 128'hab6e47d42cec13bdf53a67b21257bddf,
              "R5 model vs vector", exp_tag[exp_tag.size()-1], 128'hab6e47d42cec13bdf53a67b21257bddf);
        wait_idle(); @(negedge clk);
        check(tag_out == 128'hab6e47d42cec13bdf53a67b21257bddf, "R5 vector tag",
              tag_out, 128'hab6e47d42cec13bdf53a67b21257bddf);
        check(tag_out2 == 32'hab6e47d4, "R6 vector truncated", 128'(tag_out2), 128'hab6e47d4);

        // R2, R3: multi-block frame
        cmd(3'd1, a1, '0, 0);
        cmd(3'd2, '0, p1, 1);
        cmd(3'd2, '0, p2, 2);
        cmd(3'd3, '0, '0, 0);

        // R8: a command during busy is dropped
        cmd(3'd1, a2, '0, 0);
        check(!cmd_ready && busy, "R8 ready low while busy", {cmd_ready, busy}, 128'h1);
        drive(3'd2, '0, p3, 3);
        cmd(3'd2, '0, p3, 0);
        cmd(3'd3, '0, '0, 0);

        // R4: single shot with AAD
        cmd(3'd4, a2, p2, 3);

        // R7: limit overflow
        cmd(3'd1, a1, '0, 0);
        for (int i = 0; i < NCTR; i++) cmd(3'd2, '0, p1 ^ 128'(i), i);
        cmd(3'd2, '0, p3, 1);
        check(err_full == 1'b1, "R7 error raised", 128'(err_full), 128'h1);
        check(exp_ct.size() == 0, "R7 no ciphertext on overflow", 128'(exp_ct.size()), '0);
        cmd(3'd3, '0, '0, 0);
        wait_idle(); @(negedge clk);
        check(err_full == 1'b1, "R7 error sticky", 128'(err_full), 128'h1);
        cmd(3'd1, a2, '0, 0);
        check(err_full == 1'b0, "R7 error cleared by open", 128'(err_full), '0);
        cmd(3'd2, '0, p2, 2);
        cmd(3'd3, '0, '0, 0);

        // R10: tag held after pulse
        wait_idle();
        repeat (6) @(negedge clk);
        check(!tag_valid && tag_out == last_tag, "R10 tag held", tag_out, last_tag);

        check(exp_ct.size() == 0 && exp_tag.size() == 0 && exp_tag32.size() == 0,
              "R3 all results seen", 128'(exp_tag.size()), '0);
        summary();
    end
endmodule